// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control section of a 3½-digit dual-slope analog-to-digital converter. The input clock is divided by four to form one count. The sequencer then steps through a repeating three-phase cycle. First it integrates the unknown signal for a fixed interval. Next it runs the reference back down, which is de-integration. Last it holds the integrator in auto-zero. The length of the de-integrate phase is the measurement. A chain of decimal counter stages measures it, and a comparator input ends it. The measured count is copied into an output register.

One full cycle is always 4000 counts, or 16,000 input clocks. Auto-zero absorbs whatever part of the de-integrate allowance goes unused, so the conversion rate does not depend on the input. The block drives three level strobes that select the analog switch setting. It also raises a one-clock pulse at the start of every phase.

The reading is held in BCD form: a half digit (0 or 1) plus three full decades. A hold input freezes the reading while conversions keep running. The reading is a level-held register rather than a stream, so it carries no handshake and no back-pressure. A consumer samples it whenever it needs the value.

Top module: `dslope_seq`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and on the first clock after it, the auto-zero strobe is high, the other strobes and the phase pulse are low, and the reading and overrange flag are zero.
- R2: Phases change only on count boundaries, and one count lasts exactly four input clocks.
- R3: The signal-integrate phase lasts exactly 1000 counts (4000 clocks).
- R4: De-integration ends at the first count boundary where the synchronized comparator is high. The reading equals the number of counts spent in de-integration. If the comparator is already high when integrate finishes, de-integration is skipped and the reading is 0.
- R5: If de-integration reaches 2000 counts, it ends. The overrange flag is set and all reading digits are zero.
- R6: Integrate start to the next integrate start is always 16,000 clocks, so auto-zero lasts 3000 counts minus the de-integrate length.
- R7: The reading is BCD: rd_digits[11:8] holds the hundreds, [7:4] the tens and [3:0] the units, each in the range 0–9. rd_half holds the thousands (0 or 1). The reading changes only on the first clock of auto-zero.
- R8: While hold is high at the end of de-integration, the reading and overrange flag keep their previous values. Conversions keep running with unchanged timing.
- R9: The comparator passes through two flip-flops before it is used. A comparator that rises at the boundary of count N of de-integration produces the reading N+1.
- R10: Exactly one phase strobe is high at any time. The phase pulse is high for the single clock on which a new phase's strobe first shows.
- R11: After reset, the first auto-zero lasts 1000 counts, so integrate begins 4000 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_zero | input | 1 | Comparator: high once the integrator has crossed zero |
| hold | input | 1 | High freezes the reading register |
| ph_int | output | 1 | Signal-integrate strobe |
| ph_deint | output | 1 | Reference de-integrate strobe |
| ph_az | output | 1 | Auto-zero strobe |
| ph_start | output | 1 | One-clock pulse on the first clock of each phase |
| rd_half | output | 1 | Thousands half digit of the reading |
| rd_digits | output | 12 | Hundreds, tens and units of the reading, BCD |
| rd_over | output | 1 | Overrange flag, latched with the reading |

## Verification
The bench targets several boundary cases:
- A comparator that is already high when integrate ends. A design that always enters de-integration would report 1 instead of 0 and shorten auto-zero.
- A de-integration that runs to 1999 counts, and one that runs out at 2000 counts. A decade carry error, or a missed overrange wrap, would show a digit above nine or a missing flag.
- A cycle run with hold high. This must leave the previous overrange reading in place while phase timing continues. A design that gated the sequence with hold would stretch the 16,000-clock period.
- The two-stage synchronizer latency. A design that sampled the comparator directly, or between count boundaries, would report the target count instead of one more.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } dsq_phase_e;

endpackage

// File: rtl/dsq_prescale.sv
module dsq_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/dsq_sync2.sv
module dsq_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/dsq_bcd_count.sv
module dsq_bcd_count #(
  parameter int NDEC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [4*NDEC-1:0] cur,
  output logic              cur_half,
  output logic [4*NDEC-1:0] nxt,
  output logic              nxt_half,
  output logic              nxt_wrap
);
  logic [NDEC:0] cy;

  assign cy[0] = 1'b1;

  for (genvar i = 0; i < NDEC; i++) begin : g_dec
    logic [3:0] d;
    assign d              = cur[4*i +: 4];
    assign nxt[4*i +: 4]  = cy[i] ? ((d == 4'd9) ? 4'd0 : d + 4'd1) : d;
    assign cy[i+1]        = cy[i] && (d == 4'd9);
  end

  assign nxt_half = cy[NDEC] ? ~cur_half : cur_half;
  assign nxt_wrap = cy[NDEC] && cur_half;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur      <= '0;
      cur_half <= 1'b0;
    end else if (inc) begin
      cur      <= nxt;
      cur_half <= nxt_half;
    end
  end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dsq_pkg::*;
#(
  parameter int DIV  = 4,
  parameter int NDEC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_zero,
  input  logic              hold,
  output logic              ph_int,
  output logic              ph_deint,
  output logic              ph_az,
  output logic              ph_start,
  output logic              rd_half,
  output logic [4*NDEC-1:0] rd_digits,
  output logic              rd_over
);
  localparam int UNIT    = 10 ** NDEC;
  localparam int INT_LEN = UNIT;
  localparam int CYCLE   = 4 * UNIT;
  localparam int AZ_POS0 = CYCLE - UNIT;
  localparam int PW      = $clog2(CYCLE);

  logic              tick;
  logic              cmp_s;
  dsq_phase_e        phase, phase_n;
  logic [PW-1:0]     pos, pos_nxt;
  logic              cnt_clr, cnt_inc, leave, ev_zero;
  logic [4*NDEC-1:0] cnt_cur, cnt_nxt;
  logic              cnt_cur_half, cnt_nxt_half, cnt_wrap;

  dsq_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dsq_sync2 u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_zero),
    .q   (cmp_s)
  );

  dsq_bcd_count #(.NDEC(NDEC)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .cur      (cnt_cur),
    .cur_half (cnt_cur_half),
    .nxt      (cnt_nxt),
    .nxt_half (cnt_nxt_half),
    .nxt_wrap (cnt_wrap)
  );

  assign pos_nxt = (pos == PW'(CYCLE - 1)) ? '0 : pos + PW'(1);

  always_comb begin
    phase_n = phase;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    leave   = 1'b0;
    ev_zero = 1'b0;
    if (tick) begin
      unique case (phase)
        PH_INT: begin
          if (pos_nxt == PW'(INT_LEN)) begin
            cnt_clr = 1'b1;
            if (cmp_s) begin
              phase_n = PH_AZ;
              leave   = 1'b1;
              ev_zero = 1'b1;
            end else begin
              phase_n = PH_DEINT;
            end
          end
        end
        PH_DEINT: begin
          if (cmp_s || cnt_wrap) begin
            phase_n = PH_AZ;
            leave   = 1'b1;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        default: begin
          if (pos_nxt == '0) phase_n = PH_INT;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_AZ;
      pos      <= PW'(AZ_POS0);
      ph_start <= 1'b0;
    end else begin
      phase    <= phase_n;
      ph_start <= tick && (phase_n != phase);
      if (tick) pos <= pos_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_digits <= '0;
      rd_half   <= 1'b0;
      rd_over   <= 1'b0;
    end else if (leave && !hold) begin
      rd_digits <= ev_zero ? '0 : cnt_nxt;
      rd_half   <= ev_zero ? 1'b0 : cnt_nxt_half;
      rd_over   <= !ev_zero && cnt_wrap;
    end
  end

  assign ph_int   = (phase == PH_INT);
  assign ph_deint = (phase == PH_DEINT);
  assign ph_az    = (phase == PH_AZ);
endmodule

// File: rtl/dsq_chk.sv
module dsq_chk #(
  parameter int NDEC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              hold,
  input logic              ph_int,
  input logic              ph_deint,
  input logic              ph_az,
  input logic              ph_start,
  input logic              rd_half,
  input logic [4*NDEC-1:0] rd_digits,
  input logic              rd_over
);
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $countones({ph_int, ph_deint, ph_az}) == 1);  // R10

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ph_start |=> !ph_start);  // R10

  AST_START_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    ({ph_int, ph_deint, ph_az} != $past({ph_int, ph_deint, ph_az})) |-> ph_start);  // R10

  AST_INT_AFTER_AZ: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_int) |-> $past(ph_az));  // R6

  AST_DEINT_AFTER_INT: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_deint) |-> $past(ph_int));  // R4

  AST_OVER_DIGITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_over |-> (rd_digits == '0 && !rd_half));  // R5

  AST_READING_AT_AZ_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(ph_start && ph_az) |-> $stable({rd_half, rd_digits, rd_over}));  // R7

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> $stable({rd_half, rd_digits, rd_over}));  // R8
endmodule

bind dslope_seq dsq_chk #(.NDEC(NDEC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hold      (hold),
  .ph_int    (ph_int),
  .ph_deint  (ph_deint),
  .ph_az     (ph_az),
  .ph_start  (ph_start),
  .rd_half   (rd_half),
  .rd_digits (rd_digits),
  .rd_over   (rd_over)
);

// File: tb/test_dslope_seq.sv
module test_dslope_seq;
  logic        clk = 1'b0;
  logic        rst, cmp_zero, hold;
  logic        ph_int, ph_deint, ph_az, ph_start, rd_half, rd_over;
  logic [11:0] rd_digits;

  always #5 clk = ~clk;

  dslope_seq i_dslope_seq (
    .clk(clk), .rst(rst), .cmp_zero(cmp_zero), .hold(hold),
    .ph_int(ph_int), .ph_deint(ph_deint), .ph_az(ph_az), .ph_start(ph_start),
    .rd_half(rd_half), .rd_digits(rd_digits), .rd_over(rd_over)
  );

  int n_chk = 0, n_fail = 0, clk_n = 0, rel_t = 0;
  int tgt = -1;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, clk_n);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int rd_val();
    return int'(rd_half) * 1000 + int'(rd_digits[11:8]) * 100 +
           int'(rd_digits[7:4]) * 10 + int'(rd_digits[3:0]);
  endfunction

  // Behavioural reference: counts in integers, phase 0=auto-zero 1=integrate 2=de-integrate
  int m_presc, m_pos, m_phase, m_e, m_rd, m_ovr, m_start, m_s1, m_s2;

  task automatic m_resolve(int ev, int c);
    if (c != 0 || ev == 2000) begin
      if (m_phase != 0) m_start = 1;
      m_phase = 0;
      m_e = 0;
      if (!hold) begin
        m_rd  = ev % 2000;
        m_ovr = (ev == 2000) ? 1 : 0;
      end
    end else begin
      if (m_phase != 2) m_start = 1;
      m_phase = 2;
      m_e = ev;
    end
  endtask

  always @(posedge clk) begin
    clk_n++;
    if (rst) begin
      m_presc = 0; m_pos = 3000; m_phase = 0; m_e = 0;
      m_rd = 0; m_ovr = 0; m_start = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      int old_s2, pn;
      old_s2 = m_s2;
      m_s2 = m_s1;
      m_s1 = int'(cmp_zero);
      m_start = 0;
      if (m_presc == 3) begin
        pn = (m_pos + 1) % 4000;
        if (m_phase == 1) begin
          if (pn == 1000) m_resolve(0, old_s2);
        end else if (m_phase == 2) begin
          m_resolve(m_e + 1, old_s2);
        end else if (pn == 0) begin
          m_phase = 1;
          m_start = 1;
        end
        m_pos = pn;
      end
      m_presc = (m_presc + 1) % 4;
    end
  end

  // Per-clock comparison, phase timing and comparator stimulus
  int int_t = -1, deint_t = 0, last_ph = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      int dut_ph, dur;
      dut_ph = ph_az ? 0 : ph_int ? 1 : ph_deint ? 2 : 3;
      check(dut_ph == m_phase, "R2 phase vs model", dut_ph, m_phase);
      check(int'(ph_start) == m_start, "R10 phase pulse vs model", int'(ph_start), m_start);
      check(rd_val() + 10000 * int'(rd_over) == m_rd + 10000 * m_ovr,
            "R7 reading vs model", rd_val() + 10000 * int'(rd_over), m_rd + 10000 * m_ovr);
      if (ph_start) begin
        if (ph_int) begin
          if (int_t < 0) check(clk_n - rel_t == 4000, "R11 first auto-zero length", clk_n - rel_t, 4000);
          else           check(clk_n - int_t == 16000, "R6 cycle period", clk_n - int_t, 16000);
          int_t = clk_n;
          last_ph = 1;
        end else if (ph_deint) begin
          check(clk_n - int_t == 4000, "R3 integrate length", clk_n - int_t, 4000);
          deint_t = clk_n;
          last_ph = 2;
        end else begin
          dur = (last_ph == 2) ? clk_n - deint_t : 0;
          if (last_ph == 1) check(clk_n - int_t == 4000, "R3 integrate length", clk_n - int_t, 4000);
          check(dur % 4 == 0, "R2 count is four clocks", dur % 4, 0);
          if (!hold)
            check(rd_val() + 10000 * int'(rd_over) == (dur / 4) % 2000 + ((dur == 8000) ? 10000 : 0),
                  "R4 reading equals de-integrate counts", rd_val() + 10000 * int'(rd_over),
                  (dur / 4) % 2000 + ((dur == 8000) ? 10000 : 0));
          last_ph = 0;
        end
      end
    end
    cmp_zero = (tgt == 0) || (tgt > 0 && ph_deint && (clk_n - deint_t) / 4 >= tgt);
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", clk_n, 116000);
    finish_run();
  end

  int tgts[7]  = '{0, 1234, 3000, 500, 1998, 1, 998};
  bit holds[7] = '{0, 0, 0, 1, 0, 0, 0};

  initial begin
    rst = 1'b1;
    hold = 1'b0;
    cmp_zero = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(ph_az && !ph_int && !ph_deint && !ph_start, "R1 reset strobes", {ph_az, ph_int, ph_deint, ph_start}, 4'b1000);
    check(rd_val() == 0 && !rd_over, "R1 reset reading", rd_val() + 10000 * int'(rd_over), 0);
    rst = 1'b0;
    rel_t = clk_n;
    @(negedge clk);
    check(ph_az && !ph_start, "R1 first clock after reset", {ph_az, ph_start}, 2'b10);
    foreach (tgts[k]) begin
      int snap, exp;
      do @(negedge clk); while (!(ph_start && ph_int));
      snap = rd_val() + 10000 * int'(rd_over);
      tgt  = tgts[k];
      hold = holds[k];
      do @(negedge clk); while (!(ph_start && ph_az));
      if (tgt == 0)             exp = 0;
      else if (tgt + 1 >= 2000) exp = 10000;
      else                      exp = tgt + 1;
      if (hold)
        check(rd_val() + 10000 * int'(rd_over) == snap, "R8 hold freezes reading", rd_val() + 10000 * int'(rd_over), snap);
      else if (tgt == 0)
        check(rd_val() + 10000 * int'(rd_over) == exp, "R4 zero-length de-integrate", rd_val() + 10000 * int'(rd_over), exp);
      else if (exp == 10000)
        check(rd_over && rd_val() == 0, "R5 overrange", rd_val() + 10000 * int'(rd_over), exp);
      else
        check(rd_val() + 10000 * int'(rd_over) == exp, "R9 synchronized comparator reading", rd_val() + 10000 * int'(rd_over), exp);
    end
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule